// File: doc/BRIEF.md
# Buffer Memory Access Arbiter

This block shares one single-port buffer memory between two requesters. One is the front-end writer, which streams incoming data into memory. The other is a processor/DMA port that reads stored data back. The front end gets most of the memory bandwidth. The processor/DMA side is held to at most one memory cycle in any four consecutive cycles. Grants are combinational in the cycle of the request. Read data comes back one cycle later, because the memory has a registered output.

A free-running slot counter steps through four slots. Slot 3 is the processor slot. Slots 0 to 2 belong to the front end. The processor may borrow a front-end slot that the front end leaves idle. The one-in-four cap still applies to every processor grant, wherever it falls. A test-enable input controls processor writes. With it low, a processor write is refused and an error pulse is raised. With it high, the processor may write as well as read.

Top module: `bufmem_arbiter`

## Requirements
- R1: In slots 0, 1 and 2, a front-end request is granted in the same cycle. The first cycle after reset release is slot 0, and the slot advances by one each cycle, wrapping from 3 to 0.
- R2: In slot 3, a legal processor request is granted in place of any front-end request, provided the processor spacing window is open.
- R3: Two processor grants are always at least four cycles apart, counting from the cycle of one grant to the cycle of the next.
- R4: When the front end is not requesting, a legal processor request may be granted in any slot, subject to the spacing of R3.
- R5: When test enable is low, a processor write request (cpu_we=1) raises cpu_err in the same cycle and gets no grant. The memory is left unchanged.
- R6: When test enable is high, a granted processor write drives mem_we=1 with the processor address and data.
- R7: A granted processor read gives exactly one cpu_rvalid pulse, in the cycle after the grant, carrying the memory data for that address. Writes give no cpu_rvalid.
- R8: In slot 3, the front end is granted if it is requesting and the processor does not take the slot.
- R9: mem_en is high only when a port is granted. mem_addr and mem_wdata come from the granted port, and front-end grants always write.
- R10: While reset is asserted, there are no grants, no memory enable, no error and no cpu_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en | input | 1 | Permits processor writes when high |
| fe_req | input | 1 | Front-end write request (held until granted) |
| fe_addr | input | AW | Front-end write address |
| fe_wdata | input | DW | Front-end write data |
| fe_gnt | output | 1 | Front-end grant, same cycle |
| cpu_req | input | 1 | Processor/DMA request |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_gnt | output | 1 | Processor grant, same cycle |
| cpu_err | output | 1 | Processor write refused (test enable low) |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read grant |
| cpu_rdata | output | DW | Read data |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Registered memory read data |

## Verification
The hardest case to reach is a processor grant in a borrowed slot that is then followed by the processor's own slot 3. Here the spacing window must override the fixed slot and hand slot 3 to the front end. The bench gets there by letting the memory go idle for more than four cycles, starting a continuous processor read on slot 1, and then turning on a continuous front-end stream. The slot-3 grant two cycles later must go to the front end. A cycle-level model of slot and spacing predicts every grant, and a queue of expected read data is drained by a monitor on each cpu_rvalid.

// File: rtl/bma_pkg.sv
// Shared types for the buffer memory access arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package bma_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_FE   = 2'd1,
        OWN_CPU  = 2'd2
    } owner_e;
endpackage

// File: rtl/bma_slot_timer.sv
// Slot timer: free-running slot counter plus a spacing counter that opens
// the processor window only after SLOTS cycles since the last processor grant.
// Assumes: SLOTS is a power of two, CPU_SLOT < SLOTS.
module bma_slot_timer #(
    parameter int SLOTS    = 4,
    parameter int CPU_SLOT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_taken,
    output logic [$clog2(SLOTS)-1:0] slot,
    output logic                     cpu_slot,
    output logic                     cpu_ready
);
    localparam int SW = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST  = SW'(SLOTS - 1);
    localparam logic [SW-1:0] CSLOT = SW'(CPU_SLOT);

    logic [SW-1:0] slot_q;
    logic [SW-1:0] gap_q;

    // Advance the slot by one each cycle, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)             slot_q <= '0;
        else if (slot_q == LAST) slot_q <= '0;
        else                    slot_q <= slot_q + 1'b1;
    end

    // Count cycles since the last processor grant, saturating when the window opens.
    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= LAST;
        else if (cpu_taken)     gap_q <= '0;
        else if (gap_q != LAST) gap_q <= gap_q + 1'b1;
    end

    assign slot      = slot_q;
    assign cpu_slot  = (slot_q == CSLOT);
    assign cpu_ready = (gap_q == LAST);
endmodule

// File: rtl/bma_grant.sv
// Grant logic: picks the owner of the current memory cycle.
// Front end wins outside the processor slot; processor wins its slot when the
// window is open; an idle slot may be lent to either. Illegal processor writes
// are refused with cpu_err and never granted.
// Assumes: inputs are stable for the whole cycle.
module bma_grant
    import bma_pkg::*;
(
    input  logic run,
    input  logic cpu_slot,
    input  logic cpu_ready,
    input  logic test_en,
    input  logic fe_req,
    input  logic cpu_req,
    input  logic cpu_we,
    output logic fe_gnt,
    output logic cpu_gnt,
    output logic cpu_err
);
    owner_e owner;
    logic   cpu_legal;

    assign cpu_legal = cpu_req && (!cpu_we || test_en) && cpu_ready;

    // Choose the owner of this cycle from slot, window and requests.
    always_comb begin
        owner = OWN_NONE;
        if (run) begin
            if (cpu_slot) begin
                if (cpu_legal)   owner = OWN_CPU;
                else if (fe_req) owner = OWN_FE;
            end else begin
                if (fe_req)         owner = OWN_FE;
                else if (cpu_legal) owner = OWN_CPU;
            end
        end
    end

    assign fe_gnt  = (owner == OWN_FE);
    assign cpu_gnt = (owner == OWN_CPU);
    assign cpu_err = run && cpu_req && cpu_we && !test_en;
endmodule

// File: rtl/bma_rdret.sv
// Read return: flags a processor read one cycle after its grant, aligned with
// the registered memory output.
// Assumes: memory read latency of exactly one cycle.
module bma_rdret #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_taken,
    input  logic [DW-1:0] mem_rdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    logic valid_q;

    // Remember that the previous cycle was a granted processor read.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= rd_taken;
    end

    assign rvalid = valid_q;
    assign rdata  = mem_rdata;
endmodule

// File: rtl/bufmem_arbiter.sv
// Buffer memory access arbiter top: shares a single-port memory between the
// front-end writer and the processor/DMA port with a 1-in-SLOTS processor cap.
// Assumes: synchronous memory with one-cycle registered read data.
module bufmem_arbiter #(
    parameter int AW       = 8,
    parameter int DW       = 16,
    parameter int SLOTS    = 4,
    parameter int CPU_SLOT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en,
    input  logic          fe_req,
    input  logic [AW-1:0] fe_addr,
    input  logic [DW-1:0] fe_wdata,
    output logic          fe_gnt,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic          cpu_err,
    output logic          cpu_rvalid,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    localparam int SW = $clog2(SLOTS);

    logic [SW-1:0] slot;
    logic          cpu_slot;
    logic          cpu_ready;

    bma_slot_timer #(.SLOTS(SLOTS), .CPU_SLOT(CPU_SLOT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_taken (cpu_gnt),
        .slot      (slot),
        .cpu_slot  (cpu_slot),
        .cpu_ready (cpu_ready)
    );

    bma_grant u_grant (
        .run       (rst_n),
        .cpu_slot  (cpu_slot),
        .cpu_ready (cpu_ready),
        .test_en   (test_en),
        .fe_req    (fe_req),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .fe_gnt    (fe_gnt),
        .cpu_gnt   (cpu_gnt),
        .cpu_err   (cpu_err)
    );

    bma_rdret #(.DW(DW)) u_rdret (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_taken  (cpu_gnt && !cpu_we),
        .mem_rdata (mem_rdata),
        .rvalid    (cpu_rvalid),
        .rdata     (cpu_rdata)
    );

    // Steer the memory port to whichever requester owns this cycle.
    always_comb begin
        mem_en    = fe_gnt || cpu_gnt;
        mem_we    = fe_gnt || (cpu_gnt && cpu_we);
        mem_addr  = cpu_gnt ? cpu_addr  : fe_addr;
        mem_wdata = cpu_gnt ? cpu_wdata : fe_wdata;
    end
endmodule

// File: rtl/bufmem_arbiter_chk.sv
// Checker for bufmem_arbiter: protocol and scheduling properties.
// Assumes: bound to every bufmem_arbiter instance with default SLOTS.
module bufmem_arbiter_chk #(
    parameter int SLOTS    = 4,
    parameter int CPU_SLOT = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     test_en,
    input logic                     fe_req,
    input logic                     fe_gnt,
    input logic                     cpu_req,
    input logic                     cpu_we,
    input logic                     cpu_gnt,
    input logic                     cpu_err,
    input logic                     cpu_rvalid,
    input logic                     mem_en,
    input logic                     mem_we,
    input logic [$clog2(SLOTS)-1:0] slot
);
    localparam int SW = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic [SW-1:0] since_q;

    // Independent count of cycles since the last processor grant.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_q <= LAST;
        else if (cpu_gnt)        since_q <= '0;
        else if (since_q != LAST) since_q <= since_q + 1'b1;
    end

    a_r1_fe_served: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_req && slot != SW'(CPU_SLOT)) |-> fe_gnt);

    a_r3_cpu_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_gnt |-> (since_q == LAST));

    a_r5_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !test_en) |-> (cpu_err && !cpu_gnt));

    a_r5_no_illegal_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (fe_gnt || test_en));

    a_r7_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt && !cpu_we) |=> cpu_rvalid);

    a_r7_rvalid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(cpu_gnt && !cpu_we));

    a_r9_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fe_gnt, cpu_gnt}) && (mem_en == (fe_gnt || cpu_gnt)));
endmodule

bind bufmem_arbiter bufmem_arbiter_chk #(.SLOTS(SLOTS), .CPU_SLOT(CPU_SLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .fe_req     (fe_req),
    .fe_gnt     (fe_gnt),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_gnt    (cpu_gnt),
    .cpu_err    (cpu_err),
    .cpu_rvalid (cpu_rvalid),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .slot       (slot)
);

// File: tb/bufmem_arbiter_tb_top.sv
// Scoreboard bench: drivers push expected read data; a monitor pops on cpu_rvalid.
module bufmem_arbiter_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic          fe_req = 1'b0;
    logic [AW-1:0] fe_addr = '0;
    logic [DW-1:0] fe_wdata = '0;
    logic          fe_gnt;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_gnt, cpu_err, cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] ram [0:(1<<AW)-1];
    logic [DW-1:0] shadow [0:(1<<AW)-1];
    logic [DW-1:0] expq [$];

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int last_cpu = -100;
    int mon_last = -100;
    int off_slot_grants = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bufmem_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .test_en(test_en),
        .fe_req(fe_req), .fe_addr(fe_addr), .fe_wdata(fe_wdata), .fe_gnt(fe_gnt),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_gnt(cpu_gnt), .cpu_err(cpu_err), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Synchronous single-port memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    // Cycle count since reset release; slot = cyc % 4.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected read data on cpu_rvalid, and watch processor spacing.
    always @(negedge clk) begin
        #2;
        if (rst_n && cpu_rvalid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R7", "unexpected rvalid", 1, 0);
            end else begin
                logic [DW-1:0] e;
                e = expq.pop_front();
                chk(cpu_rdata == e, "R7", "read data", int'(cpu_rdata), int'(e));
            end
        end
        if (rst_n && cpu_gnt) begin
            chk(cyc - mon_last >= 4, "R3", "grant spacing", cyc - mon_last, 4);
            mon_last = cyc;
        end
    end

    // Contended or idle traffic against a cycle model of slot and spacing.
    task automatic run_mix(input int n, input bit fe_on, input int fe_base, inout int ra);
        for (int i = 0; i < n; i++) begin
            bit exp_cpu, exp_fe;
            int slot;
            fe_req   = fe_on;
            fe_addr  = AW'(fe_base + i);
            fe_wdata = DW'(16'h5000 + fe_base + i);
            cpu_req  = 1'b1;
            cpu_we   = 1'b0;
            cpu_addr = AW'(ra % 16);
            #2;
            slot    = cyc % 4;
            exp_cpu = (cyc - last_cpu >= 4) && (!fe_on || slot == 3);
            exp_fe  = fe_on && !exp_cpu;
            chk(cpu_gnt == exp_cpu, slot == 3 ? "R2" : "R4", "cpu_gnt", cpu_gnt, exp_cpu);
            chk(fe_gnt == exp_fe, slot == 3 ? "R8" : "R1", "fe_gnt", fe_gnt, exp_fe);
            if (cpu_gnt) begin
                expq.push_back(shadow[ra % 16]);
                last_cpu = cyc;
                if (slot != 3) off_slot_grants++;
                ra++;
            end
            if (fe_gnt) shadow[fe_base + i] = fe_wdata;
            @(negedge clk);
        end
        fe_req  = 1'b0;
        cpu_req = 1'b0;
    endtask

    task automatic idle(input int n);
        fe_req = 1'b0; cpu_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Single processor read, held until granted.
    task automatic cpu_read(input int a);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(a);
        for (int k = 0; k < 8; k++) begin
            #2;
            if (cpu_gnt) begin
                expq.push_back(shadow[a]);
                last_cpu = cyc;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        cpu_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        int ra = 0;
        for (int i = 0; i < (1 << AW); i++) begin ram[i] = '0; shadow[i] = '0; end

        // R10: requests during reset are not served.
        fe_req = 1'b1; cpu_req = 1'b1; cpu_we = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk(!fe_gnt && !cpu_gnt, "R10", "grants in reset", fe_gnt | cpu_gnt, 0);
        chk(!mem_en && !cpu_err, "R10", "mem_en/err in reset", mem_en | cpu_err, 0);
        chk(!cpu_rvalid, "R10", "rvalid in reset", cpu_rvalid, 0);
        fe_req = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R8/R9: front-end stream alone owns every slot.
        for (int i = 0; i < 16; i++) begin
            fe_req = 1'b1; fe_addr = AW'(i); fe_wdata = DW'(i * 37 + 5);
            #2;
            chk(fe_gnt, (cyc % 4 == 3) ? "R8" : "R1", "fe_gnt alone", fe_gnt, 1);
            chk(mem_en && mem_we, "R9", "fe write enables", {mem_en, mem_we}, 3);
            chk(mem_addr == AW'(i) && mem_wdata == fe_wdata, "R9", "fe addr",
                int'(mem_addr), i);
            shadow[i] = fe_wdata;
            @(negedge clk);
        end
        idle(5);

        // R2/R3/R1: contention, processor only in its slot.
        run_mix(20, 1'b1, 32, ra);

        // R4 then R3/R8: borrow from slot 1, then slot 3 goes to the front end.
        idle(5);
        while (cyc % 4 != 1) @(negedge clk);
        off_slot_grants = 0;
        run_mix(9, 1'b0, 0, ra);
        chk(off_slot_grants > 0, "R4", "borrowed grants", off_slot_grants, 1);
        cpu_req = 1'b1;
        run_mix(8, 1'b1, 64, ra);

        // R5: refused write with test enable low.
        idle(5);
        test_en = 1'b0;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'd5; cpu_wdata = 16'hBEEF;
        #2;
        chk(cpu_err, "R5", "cpu_err", cpu_err, 1);
        chk(!cpu_gnt && !mem_en, "R5", "refused write no access", cpu_gnt | mem_en, 0);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #2;
        chk(!cpu_err && !cpu_rvalid, "R5", "err pulse ends", cpu_err | cpu_rvalid, 0);
        @(negedge clk);
        idle(4);
        cpu_read(5);   // R5: monitor expects the old data at address 5

        // R6: permitted write in test mode.
        idle(5);
        test_en = 1'b1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'd6; cpu_wdata = 16'h1234;
        #2;
        chk(cpu_gnt && !cpu_err, "R6", "test write granted", cpu_gnt, 1);
        chk(mem_we && mem_addr == 8'd6 && mem_wdata == 16'h1234, "R6", "test write drive",
            int'(mem_wdata), 16'h1234);
        shadow[6] = 16'h1234;
        last_cpu = cyc;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #2;
        chk(!cpu_rvalid, "R7", "no rvalid after write", cpu_rvalid, 0);
        @(negedge clk);
        idle(4);
        cpu_read(6);
        test_en = 1'b0;

        idle(6);
        chk(expq.size() == 0, "R7", "all reads returned", expq.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule